// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block is the timing core of a small two-stage processor pipeline. It divides the incoming oscillator clock into four phase slots, numbered one to four, and one of them is active in each oscillator cycle. Four slots make one instruction cycle. Within every instruction cycle the block fetches one program word while it executes the word fetched in the previous cycle. So straight-line code retires one instruction per instruction cycle.

Each pipeline action belongs to a fixed slot. The program counter steps in slot one. The data-memory operand read strobe fires in slot two. The destination write strobe and the latch of the fetched word into the instruction register both happen in slot four. The decoder reports a taken jump or call through a request and a target address, which are sampled in slot four. The prefetched word is then discarded, and the following instruction cycle is a bubble that executes nothing while the target is fetched. Decode, ALU and memories sit outside the block.

Top module: `qps_seq`

## Requirements
- R1: `phase_o` is one-hot, with bit 0 for slot one through bit 3 for slot four, and it advances one slot per clock in the order 1, 2, 3, 4, 1.
- R2: Reset is asynchronous and active low. While it is held, `phase_o` is 4'b0001, `pc_o` equals `RESET_VEC`, `exec_valid_o` is 0, `ir_o` is 0 and both data-memory strobes are low. Its release is synchronised in two stages, so the first slot-two state follows the third rising edge after release.
- R3: At the clock edge that ends slot one of an executing cycle (`exec_valid_o`=1), the program counter increases by one, modulo 2^ADDR_W. It changes at no other edge except a branch load.
- R4: `prog_addr_o` always equals `pc_o`. At the edge that ends slot four, `ir_o` takes `prog_data_i`, and it is stable at every other edge.
- R5: The first instruction cycle after reset and the cycle after a taken branch have `exec_valid_o`=0. Every other cycle has `exec_valid_o`=1. The flag changes only at the end of slot four.
- R6: `dm_rd_o` is high exactly in slot two of cycles with `exec_valid_o`=1.
- R7: `dm_wr_o` is high exactly in slot four of cycles with `exec_valid_o`=1.
- R8: If `br_req_i` is high at the edge ending slot four of an executing cycle, `pc_o` takes `br_target_i` at that edge and the next cycle is a bubble.
- R9: `br_req_i` has no effect in slots one to three, and no effect in any slot of a bubble cycle.
- R10: After a taken branch, the word at the target is fetched during the bubble cycle and executed in the cycle after it, two instruction cycles after the branching one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_addr_o | output | ADDR_W | Program memory fetch address |
| prog_data_i | input | WORD_W | Program word read at `prog_addr_o` |
| br_req_i | input | 1 | Decoder reports a PC-changing instruction |
| br_target_i | input | ADDR_W | Branch destination address |
| dm_rd_o | output | 1 | Data memory operand read strobe |
| dm_wr_o | output | 1 | Data memory destination write strobe |
| phase_o | output | 4 | One-hot phase slot |
| exec_valid_o | output | 1 | Execute stage holds a real instruction |
| pc_o | output | ADDR_W | Program counter |
| ir_o | output | WORD_W | Instruction register |

## Verification
Every output is a register or a decode of registers, so a change driven by an edge is visible in the oscillator cycle right after it. The PC step shows one clock after slot one begins. The branch load, the new instruction word and the new valid flag show one clock after slot four begins. The strobes follow the phase of the same cycle. The bench drives inputs and compares outputs on falling edges. At each falling edge it checks the outputs against a reference state that it advances once per clock, so each result is compared in the first cycle it is due. Branch outcomes are also traced across the two instruction cycles that follow.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int unsigned NPH  = 4;
  localparam int unsigned PH_W = $clog2(NPH);
  typedef logic [PH_W-1:0] ph_idx_t;
  localparam ph_idx_t PH_Q1 = ph_idx_t'(0);
  localparam ph_idx_t PH_Q2 = ph_idx_t'(1);
  localparam ph_idx_t PH_Q4 = ph_idx_t'(3);
endpackage

// File: rtl/qps_rst_sync.sv
module qps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/qps_phase_gen.sv
module qps_phase_gen
  import qps_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [NPH-1:0] phase_o
);
  ph_idx_t cnt_q, cnt_d;

  always_comb cnt_d = ph_idx_t'(cnt_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= PH_Q1;
    else         cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_dec
    assign phase_o[g] = (cnt_q == ph_idx_t'(g));
  end
endmodule

// File: rtl/qps_pc_unit.sv
module qps_pc_unit #(
  parameter int unsigned        ADDR_W    = 9,
  parameter logic [ADDR_W-1:0]  RESET_VEC = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              pc_en;

  always_comb begin
    pc_d = pc_q;
    if (load_en_i)      pc_d = target_i;
    else if (step_en_i) pc_d = pc_q + 1'b1;
  end

  assign pc_en = step_en_i | load_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= RESET_VEC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/qps_pipe.sv
module qps_pipe #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_en_i,
  input  logic              flush_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] ir_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] ir_q, ir_d;
  logic              vld_q, vld_d;

  always_comb begin
    ir_d  = word_i;
    vld_d = ~flush_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= '0;
      vld_q <= 1'b0;
    end else if (latch_en_i) begin
      ir_q  <= ir_d;
      vld_q <= vld_d;
    end
  end

  assign ir_o    = ir_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/qps_seq.sv
module qps_seq
  import qps_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 9,
  parameter int unsigned       WORD_W    = 12,
  parameter logic [ADDR_W-1:0] RESET_VEC = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] prog_addr_o,
  input  logic [WORD_W-1:0] prog_data_i,
  input  logic              br_req_i,
  input  logic [ADDR_W-1:0] br_target_i,
  output logic              dm_rd_o,
  output logic              dm_wr_o,
  output logic [NPH-1:0]    phase_o,
  output logic              exec_valid_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [WORD_W-1:0] ir_o
);
  logic              rst_n_s;
  logic [NPH-1:0]    ph;
  logic              ev;
  logic              br_take;
  logic [ADDR_W-1:0] pc;

  qps_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  qps_phase_gen u_ph (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .phase_o(ph)
  );

  // a taken branch is only honoured at the end of slot four of a real instruction
  assign br_take = ph[PH_Q4] & ev & br_req_i;

  qps_pc_unit #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .step_en_i(ph[PH_Q1] & ev),
    .load_en_i(br_take),
    .target_i (br_target_i),
    .pc_o     (pc)
  );

  qps_pipe #(.WORD_W(WORD_W)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .latch_en_i(ph[PH_Q4]),
    .flush_i   (br_take),
    .word_i    (prog_data_i),
    .ir_o      (ir_o),
    .valid_o   (ev)
  );

  assign prog_addr_o  = pc;
  assign pc_o         = pc;
  assign phase_o      = ph;
  assign exec_valid_o = ev;
  assign dm_rd_o      = ph[PH_Q2] & ev;
  assign dm_wr_o      = ph[PH_Q4] & ev;
endmodule

// File: rtl/qps_seq_chk.sv
module qps_seq_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned WORD_W = 12
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [3:0]        phase,
  input logic              ev,
  input logic              rd,
  input logic              wr,
  input logic              br_req,
  input logic [ADDR_W-1:0] br_tgt,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] ir
);
  p_phase_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones(phase) == 1);
  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    phase[0] |=> phase[1]);
  p_phase_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    phase[3] |=> phase[0]);
  p_pc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (phase[1] || phase[2]) |=> $stable(pc));
  p_bubble_no_step_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (phase[0] && !ev) |=> $stable(pc));
  p_ir_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !phase[3] |=> $stable(ir) && $stable(ev));
  p_rd_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd |-> (phase[1] && ev));
  p_wr_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr |-> (phase[3] && ev));
  p_branch_load_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (phase[3] && ev && br_req) |=> (pc == $past(br_tgt) && !ev));
endmodule

bind qps_seq qps_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i (clk_i),
  .rst_n (rst_n_s),
  .phase (phase_o),
  .ev    (exec_valid_o),
  .rd    (dm_rd_o),
  .wr    (dm_wr_o),
  .br_req(br_req_i),
  .br_tgt(br_target_i),
  .pc    (pc_o),
  .ir    (ir_o)
);

// File: tb/qps_seq_tb_top.sv
`timescale 1ns/1ps
module qps_seq_tb_top;
  localparam int unsigned AW = 9;
  localparam int unsigned WW = 12;
  localparam logic [AW-1:0] RV = 9'h1FF;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] prog_addr_o;
  logic [WW-1:0] prog_data_i;
  logic          br_req_i;
  logic [AW-1:0] br_target_i;
  logic          dm_rd_o, dm_wr_o, exec_valid_o;
  logic [3:0]    phase_o;
  logic [AW-1:0] pc_o;
  logic [WW-1:0] ir_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  function automatic logic [WW-1:0] memf(input logic [AW-1:0] a);
    return {a[2:0], a} ^ 12'hA5C;
  endfunction

  assign prog_data_i = memf(prog_addr_o);

  qps_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_addr_o(prog_addr_o),
    .prog_data_i(prog_data_i), .br_req_i(br_req_i), .br_target_i(br_target_i),
    .dm_rd_o(dm_rd_o), .dm_wr_o(dm_wr_o), .phase_o(phase_o),
    .exec_valid_o(exec_valid_o), .pc_o(pc_o), .ir_o(ir_o)
  );

  // reference state
  int            e_ph;
  logic [AW-1:0] e_pc;
  logic          e_ev;
  logic [WW-1:0] e_ir;
  string         pc_tag;
  string         ir_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 phase", 32'(phase_o), 32'(4'b0001 << e_ph));
    chk(pc_tag, 32'(pc_o), 32'(e_pc));
    chk("R4 addr", 32'(prog_addr_o), 32'(e_pc));
    chk(ir_tag, 32'(ir_o), 32'(e_ir));
    chk("R5 valid", 32'(exec_valid_o), 32'(e_ev));
    chk("R6 rd", 32'(dm_rd_o), 32'(e_ev && e_ph == 1));
    chk("R7 wr", 32'(dm_wr_o), 32'(e_ev && e_ph == 3));
  endtask

  // mode 0 random, 1 always request, 2 never request
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      logic          take;
      logic [AW-1:0] n_pc;
      check_all();
      case (mode)
        1:       br_req_i = 1'b1;
        2:       br_req_i = 1'b0;
        default: br_req_i = ($urandom_range(0, 5) == 0);
      endcase
      br_target_i = ($urandom_range(0, 7) == 0) ? RV : AW'($urandom);
      take = (e_ph == 3) && e_ev && br_req_i;
      n_pc = e_pc;
      pc_tag = "R3 pc";
      if (e_ph == 0 && e_ev) n_pc = e_pc + 1'b1;
      if (take) begin
        n_pc = br_target_i;
        pc_tag = "R8 pc load";
      end else if (br_req_i) pc_tag = "R9 pc ignores request";
      @(negedge clk_i);
      if (e_ph == 3) begin
        ir_tag = (!e_ev) ? "R10 target word" : "R4 ir";
        e_ir = memf(e_pc);
        e_ev = !take;
      end
      e_pc = n_pc;
      e_ph = (e_ph + 1) % 4;
    end
    br_req_i = 1'b0;
  endtask

  task automatic release_reset();
    bit seen = 0;
    rst_ni = 1'b1;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk_i);
      if (phase_o == 4'b0010) seen = 1;
    end
    chk("R2 release to slot two", 32'(seen), 32'd1);
    e_ph = 1; e_pc = RV; e_ev = 1'b0; e_ir = '0;
    pc_tag = "R3 pc"; ir_tag = "R4 ir";
  endtask

  task automatic reset_state(input string tag);
    chk({tag, " phase"}, 32'(phase_o), 32'h1);
    chk({tag, " pc"}, 32'(pc_o), 32'(RV));
    chk({tag, " valid"}, 32'(exec_valid_o), 32'd0);
    chk({tag, " ir"}, 32'(ir_o), 32'd0);
    chk({tag, " strobes"}, 32'({dm_rd_o, dm_wr_o}), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EC0_0D17));
    rst_ni = 1'b0; br_req_i = 1'b0; br_target_i = '0;
    repeat (3) @(negedge clk_i);
    reset_state("R2 reset");
    release_reset();
    run(200, 2);    // straight-line code, wraps from RV to 0
    run(400, 1);    // request every cycle: branches alternate with bubbles
    run(4000, 0);   // random mix
    // mid-run asynchronous reset
    #2 rst_ni = 1'b0;
    #1 reset_state("R2 async");
    @(negedge clk_i);
    release_reset();
    run(800, 0);
    run(100, 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule